// File: doc/BRIEF.md
# Scaled Watchdog Timer with Interrupt Reload

This block is a system watchdog built around three byte-wide registers: a
control byte, a countdown byte and a status/enable byte. Software arms the
watchdog by writing a non-zero count and disarms it by writing zero. The
count falls by one per time unit. The unit is either one tick of the
external one-second strobe, or sixty such ticks, depending on a scale bit.
When the count runs out, or a timeout is forced, the block sets a sticky
fired flag and raises a one-cycle timeout event. It can also hold a
keyboard-reset line low for a fixed number of clocks.

Keyboard and mouse interrupt activity can, when enabled, reload the countdown
from the last value software wrote. A keyboard gate input can force a
timeout, and so can a self-clearing force bit. A fired watchdog stays
inert, with its count pinned at zero, until software clears the flag.

Top module: `scaled_watchdog`

## Requirements
- R1: Writing 0 to the count register (address 1) disarms the timer: the count reads 0 and stays there, and time ticks cause no timeout.
- R2: Writing a non-zero value to address 1 loads it, and the value reads back one cycle later. The prescaler is cleared. Each time unit then lowers the count by one.
- R3: Control bit 3 (address 0) selects the unit: 0 means every `secTick` cycle, and 1 means every 60th `secTick` counted from the last load or reload.
- R4: When the count steps from 1 to 0, status bit 4 (address 2) reads 1 and `timeoutIrq` is high for exactly one cycle, both from the clock edge of that step.
- R5: The fired flag (status bit 4) is sticky. Only a status write with bit 4 = 0 clears it. While it is set the count reads 0, count writes are ignored and reload events are ignored.
- R6: With status bit 6 set, a `kbdIrq` cycle reloads an armed count with the last written count value. Status bit 7 does the same for `mouseIrq`. With the bit clear, the interrupt has no effect.
- R7: Writing status bit 5 = 1 forces a timeout at the next clock edge. Bit 5 reads 1 for that one cycle only, then 0.
- R8: With control bit 2 set, a `kbdP20` cycle forces a timeout at that edge. With control bit 2 clear, `kbdP20` is ignored.
- R9: With control bit 1 set, a timeout drives `kbdRstN` low for PULSE_CLKS cycles, starting with the edge that sets the fired flag. With bit 1 clear, `kbdRstN` stays high.
- R10: `irqSource` always equals status bits 3:0 as last written.
- R11: After reset all three registers read 0, `kbdRstN` is high and `timeoutIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 count, 2 status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register (combinational) |
| secTick | input | 1 | One-cycle pulse per second |
| kbdIrq | input | 1 | Keyboard interrupt activity |
| mouseIrq | input | 1 | Mouse interrupt activity |
| kbdP20 | input | 1 | Keyboard gate force-timeout input |
| kbdRstN | output | 1 | Active-low keyboard reset pulse |
| timeoutIrq | output | 1 | One-cycle timeout event |
| irqSource | output | 4 | Interrupt source code chosen by software |

## Verification
Any wrong internal state here reaches the ports within a single cycle. The count and the fired flag read straight back, so a stale prescaler phase shows up as a count that changes one second early or late. A missed reload shows up as a count lower than expected at the next read. A force bit that fails to clear re-fires as soon as the flag is cleared. A behavioural model that advances on every edge exposes each of these on the first cycle they differ from it. Directed reads then confirm the boundary cases: the 59/60 tick edge, ignored writes while fired, and disabled reload sources.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // control byte bit positions
  localparam int CTL_PULSE_EN = 1;
  localparam int CTL_P20_EN   = 2;
  localparam int CTL_SCALE    = 3;

  // status byte bit positions
  localparam int ST_SRC_LSB  = 0;
  localparam int ST_SRC_W    = 4;
  localparam int ST_FIRED    = 4;
  localparam int ST_FORCE    = 5;
  localparam int ST_KBD_EN   = 6;
  localparam int ST_MOUSE_EN = 7;

  typedef struct packed {
    logic             loadCount;
    logic             reload;
    logic             fire;
    logic             scale;
    logic             pulseEn;
    logic [REG_W-1:0] loadVal;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             kbdIrq,
  input  logic             mouseIrq,
  input  logic             kbdP20,
  input  logic             expire,
  input  logic             countNz,
  output wdtStrobe_t       strb,
  output logic [REG_W-1:0] ctrlReg,
  output logic [REG_W-1:0] statusReg,
  output logic             firedFlag,
  output logic             timeoutIrq
);
  logic mouseEn, kbdEn, forceReq;
  logic [ST_SRC_W-1:0] srcSel;
  logic wrCtrl, wrCount, wrStat;
  logic fireNow, reloadNow, p20Force, irqHit;

  always_comb begin
    wrCtrl  = regWrEn && (regSel_e'(regAddr) == SEL_CTRL);
    wrCount = regWrEn && (regSel_e'(regAddr) == SEL_COUNT);
    wrStat  = regWrEn && (regSel_e'(regAddr) == SEL_STAT);
  end

  assign p20Force  = ctrlReg[CTL_P20_EN] && kbdP20;
  assign fireNow   = !firedFlag && (forceReq || p20Force || expire);
  assign irqHit    = (kbdIrq && kbdEn) || (mouseIrq && mouseEn);
  assign reloadNow = !firedFlag && countNz && irqHit;

  always_comb begin
    strb           = '0;
    strb.fire      = fireNow;
    strb.loadCount = wrCount && !firedFlag;
    strb.reload    = reloadNow;
    strb.scale     = ctrlReg[CTL_SCALE];
    strb.pulseEn   = ctrlReg[CTL_PULSE_EN];
    strb.loadVal   = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mouseEn  <= 1'b0;
      kbdEn    <= 1'b0;
      srcSel   <= '0;
      forceReq <= 1'b0;
    end else begin
      forceReq <= wrStat && regWrData[ST_FORCE];
      if (wrStat) begin
        mouseEn <= regWrData[ST_MOUSE_EN];
        kbdEn   <= regWrData[ST_KBD_EN];
        srcSel  <= regWrData[ST_SRC_LSB +: ST_SRC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firedFlag  <= 1'b0;
      timeoutIrq <= 1'b0;
    end else begin
      timeoutIrq <= fireNow;
      if (fireNow) begin
        firedFlag <= 1'b1;
      end else if (wrStat && !regWrData[ST_FIRED]) begin
        firedFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    statusReg                          = '0;
    statusReg[ST_MOUSE_EN]             = mouseEn;
    statusReg[ST_KBD_EN]               = kbdEn;
    statusReg[ST_FORCE]                = forceReq;
    statusReg[ST_FIRED]                = firedFlag;
    statusReg[ST_SRC_LSB +: ST_SRC_W]  = srcSel;
  end
endmodule

// File: rtl/wdt_datapath.sv
`timescale 1ns/1ps
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRESCALE   = 60,
  parameter int PULSE_CLKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  wdtStrobe_t       strb,
  output logic [REG_W-1:0] curCount,
  output logic             expire,
  output logic             countNz,
  output logic             kbdRstN
);
  localparam int PULSE_W = $clog2(PULSE_CLKS + 1);

  logic [REG_W-1:0]   reloadVal;
  logic [PULSE_W-1:0] pulseCnt;
  logic               pscWrap;
  logic               unitTick;

  generate
    if (PRESCALE > 1) begin : g_psc
      localparam int PSC_W = $clog2(PRESCALE);
      localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PRESCALE - 1);
      logic [PSC_W-1:0] psc;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          psc <= '0;
        end else if (strb.loadCount || strb.reload) begin
          psc <= '0;
        end else if (secTick) begin
          psc <= (psc == PSC_LAST) ? '0 : psc + 1'b1;
        end
      end
      assign pscWrap = secTick && (psc == PSC_LAST);
    end else begin : g_nopsc
      assign pscWrap = secTick;
    end
  endgenerate

  assign unitTick = strb.scale ? pscWrap : secTick;
  assign countNz  = (curCount != '0);
  assign expire   = unitTick && (curCount == REG_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount  <= '0;
      reloadVal <= '0;
    end else begin
      if (strb.loadCount) begin
        reloadVal <= strb.loadVal;
      end
      if (strb.fire) begin
        curCount <= '0;
      end else if (strb.loadCount) begin
        curCount <= strb.loadVal;
      end else if (strb.reload) begin
        curCount <= reloadVal;
      end else if (unitTick && countNz) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.fire && strb.pulseEn) begin
      pulseCnt <= PULSE_W'(PULSE_CLKS);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign kbdRstN = (pulseCnt == '0);
endmodule

// File: rtl/scaled_watchdog.sv
`timescale 1ns/1ps
module scaled_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESCALE   = 60,
  parameter int PULSE_CLKS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                secTick,
  input  logic                kbdIrq,
  input  logic                mouseIrq,
  input  logic                kbdP20,
  output logic                kbdRstN,
  output logic                timeoutIrq,
  output logic [3:0]          irqSource
);
  wdtStrobe_t       strb;
  logic [REG_W-1:0] ctrlReg, statusReg, curCount;
  logic             firedFlag, expire, countNz;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .kbdP20(kbdP20),
    .expire(expire), .countNz(countNz),
    .strb(strb), .ctrlReg(ctrlReg), .statusReg(statusReg),
    .firedFlag(firedFlag), .timeoutIrq(timeoutIrq)
  );

  wdt_datapath #(.PRESCALE(PRESCALE), .PULSE_CLKS(PULSE_CLKS)) u_dp (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strb(strb),
    .curCount(curCount), .expire(expire), .countNz(countNz),
    .kbdRstN(kbdRstN)
  );

  always_comb begin
    unique case (regSel_e'(regAddr))
      SEL_CTRL:  regRdData = ctrlReg;
      SEL_COUNT: regRdData = curCount;
      SEL_STAT:  regRdData = statusReg;
      default:   regRdData = '0;
    endcase
  end

  assign irqSource = statusReg[ST_SRC_LSB +: ST_SRC_W];
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] regAddr,
  input logic [7:0] curCount,
  input logic       firedFlag,
  input logic       timeoutIrq,
  input logic       kbdRstN
);
  // R1: a zero count stays zero unless software loads a new one
  p_idle_stays_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == 8'd0 && !(wrEn && regAddr == 2'd1)) |=> (curCount == 8'd0));

  // R4: the fired flag rises together with the timeout event
  p_fire_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firedFlag) |-> timeoutIrq);

  // R5: count pinned at zero while fired
  p_fired_count_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    firedFlag |-> (curCount == 8'd0));

  // R5: only a status write can clear the flag
  p_fired_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (firedFlag && !(wrEn && regAddr == 2'd2)) |=> firedFlag);

  // R9: reset pulse only starts on a fresh timeout
  p_pulse_on_fire_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kbdRstN) |-> $rose(firedFlag));
endmodule

bind scaled_watchdog wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(regWrEn), .regAddr(regAddr),
  .curCount(curCount), .firedFlag(firedFlag),
  .timeoutIrq(timeoutIrq), .kbdRstN(kbdRstN)
);

// File: tb/sim_scaled_watchdog.sv
`timescale 1ns/1ps
module sim_scaled_watchdog;
  localparam int PRE   = 60;
  localparam int PULSE = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic       secTick = 1'b0, kbdIrq = 1'b0, mouseIrq = 1'b0, kbdP20 = 1'b0;
  logic [7:0] regRdData;
  logic       kbdRstN, timeoutIrq;
  logic [3:0] irqSource;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scaled_watchdog #(.PRESCALE(PRE), .PULSE_CLKS(PULSE)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .secTick(secTick),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq), .kbdP20(kbdP20),
    .kbdRstN(kbdRstN), .timeoutIrq(timeoutIrq), .irqSource(irqSource)
  );

  // behavioural reference model
  int mCtrl = 0, mCount = 0, mReload = 0, mPsc = 0, mPulse = 0, mSrc = 0;
  bit mMouseEn = 0, mKbdEn = 0, mForce = 0, mFired = 0, mIrq = 0;

  always @(posedge clk) begin
    bit unitT, expireT, fireT, wrC, wrS, wrK, rel;
    int nCount;
    if (!rstN) begin
      mCtrl = 0; mCount = 0; mReload = 0; mPsc = 0; mPulse = 0; mSrc = 0;
      mMouseEn = 0; mKbdEn = 0; mForce = 0; mFired = 0; mIrq = 0;
    end else begin
      wrK = regWrEn && regAddr == 2'd0;
      wrC = regWrEn && regAddr == 2'd1 && !mFired;
      wrS = regWrEn && regAddr == 2'd2;
      unitT = ((mCtrl & 8) != 0) ? (secTick && mPsc == PRE - 1) : secTick;
      expireT = unitT && mCount == 1;
      fireT = !mFired && (mForce || (((mCtrl & 4) != 0) && kbdP20) || expireT);
      rel = !mFired && mCount != 0 && ((kbdIrq && mKbdEn) || (mouseIrq && mMouseEn));
      if (fireT) nCount = 0;
      else if (wrC) nCount = regWrData;
      else if (rel) nCount = mReload;
      else if (unitT && mCount != 0) nCount = mCount - 1;
      else nCount = mCount;
      if (wrC) mReload = regWrData;
      if (wrC || rel) mPsc = 0;
      else if (secTick) mPsc = (mPsc == PRE - 1) ? 0 : mPsc + 1;
      if (fireT && ((mCtrl & 2) != 0)) mPulse = PULSE;
      else if (mPulse > 0) mPulse = mPulse - 1;
      mIrq = fireT;
      if (fireT) mFired = 1;
      else if (wrS && !regWrData[4]) mFired = 0;
      mForce = wrS && regWrData[5];
      if (wrS) begin
        mMouseEn = regWrData[7]; mKbdEn = regWrData[6]; mSrc = regWrData[3:0];
      end
      if (wrK) mCtrl = regWrData;
      mCount = nCount;
    end
  end

  function automatic int expRd(input logic [1:0] a);
    case (a)
      2'd0: return mCtrl;
      2'd1: return mCount;
      2'd2: return (int'(mMouseEn) << 7) | (int'(mKbdEn) << 6) |
                   (int'(mForce) << 5) | (int'(mFired) << 4) | mSrc;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R2 model regRdData", int'(regRdData), expRd(regAddr));
      chk("R9 model kbdRstN", int'(kbdRstN), (mPulse == 0) ? 1 : 0);
      chk("R4 model timeoutIrq", int'(timeoutIrq), int'(mIrq));
      chk("R10 model irqSource", int'(irqSource), mSrc);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    regAddr = a;
    #1.5;
    v = int'(regRdData);
  endtask

  task automatic rdReg(input logic [1:0] a, output int v);
    @(negedge clk);
    peek(a, v);
  endtask

  task automatic tickN(input int n);
    @(negedge clk);
    secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic pulseIn(input int which);
    @(negedge clk);
    if (which == 0) kbdIrq = 1'b1;
    else if (which == 1) mouseIrq = 1'b1;
    else kbdP20 = 1'b1;
    @(negedge clk);
    kbdIrq = 1'b0; mouseIrq = 1'b0; kbdP20 = 1'b0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    rdReg(2'd0, v); chk("R11 ctrl", v, 0);
    rdReg(2'd1, v); chk("R11 count", v, 0);
    rdReg(2'd2, v); chk("R11 status", v, 0);
    chk("R11 kbdRstN", int'(kbdRstN), 1);
    chk("R11 timeoutIrq", int'(timeoutIrq), 0);

    // R2 load and count in 1 s units
    wrReg(2'd0, 8'h00);
    wrReg(2'd1, 8'd5);
    rdReg(2'd1, v); chk("R2 load", v, 5);
    tickN(3);
    rdReg(2'd1, v); chk("R2 decrement", v, 2);

    // R4 expiry
    tickN(2);
    rdReg(2'd2, v); chk("R4 fired bit", v, 8'h10);
    rdReg(2'd1, v); chk("R4 count zero", v, 0);

    // R5 sticky flag, ignored load, clear
    wrReg(2'd1, 8'd9);
    rdReg(2'd1, v); chk("R5 load ignored while fired", v, 0);
    wrReg(2'd2, 8'h00);
    rdReg(2'd2, v); chk("R5 cleared", v, 0);
    wrReg(2'd1, 8'd3);
    rdReg(2'd1, v); chk("R5 load after clear", v, 3);

    // R6 reload sources
    wrReg(2'd2, 8'h40);
    tickN(2);
    pulseIn(0);
    rdReg(2'd1, v); chk("R6 keyboard reload", v, 3);
    tickN(1);
    pulseIn(1);
    rdReg(2'd1, v); chk("R6 mouse disabled", v, 2);
    wrReg(2'd2, 8'h80);
    pulseIn(1);
    rdReg(2'd1, v); chk("R6 mouse reload", v, 3);

    // R3 sixty-second unit, R9 reset pulse
    wrReg(2'd0, 8'h0A);
    wrReg(2'd1, 8'd2);
    tickN(59);
    rdReg(2'd1, v); chk("R3 no step before 60", v, 2);
    tickN(1);
    rdReg(2'd1, v); chk("R3 step at 60", v, 1);
    tickN(60);
    #1.5;
    chk("R9 pulse low", int'(kbdRstN), 0);
    rdReg(2'd2, v); chk("R4 fired scaled", v, 8'h90);
    repeat (PULSE + 1) @(negedge clk);
    #1.5;
    chk("R9 pulse ended", int'(kbdRstN), 1);

    // R7 self-clearing force
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'h00);
    wrReg(2'd1, 8'd50);
    wrReg(2'd2, 8'h20);
    peek(2'd2, v); chk("R7 force visible", v, 8'h20);
    rdReg(2'd2, v); chk("R7 force fired and cleared", v, 8'h10);
    rdReg(2'd1, v); chk("R7 count zero", v, 0);
    chk("R9 no pulse when disabled", int'(kbdRstN), 1);

    // R8 keyboard gate force
    wrReg(2'd2, 8'h00);
    wrReg(2'd1, 8'd7);
    pulseIn(2);
    rdReg(2'd1, v); chk("R8 gate ignored count", v, 7);
    rdReg(2'd2, v); chk("R8 gate ignored status", v, 0);
    wrReg(2'd0, 8'h04);
    pulseIn(2);
    rdReg(2'd2, v); chk("R8 gate fires", v, 8'h10);

    // R10 source select, R1 disarm
    wrReg(2'd2, 8'h02);
    #1.5;
    chk("R10 irqSource", int'(irqSource), 2);
    wrReg(2'd1, 8'd0);
    tickN(5);
    rdReg(2'd1, v); chk("R1 disarmed count", v, 0);
    rdReg(2'd2, v); chk("R1 no timeout", v, 8'h02);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule